// File: doc/BRIEF.md
# Flash Programming Security Gate

This block sits between a serial programming command path and a flash array. Each command is a read, a byte write, a page erase or a mass erase, with an address, write data and a flag that marks it as coming from the internal user routine instead of the external programmer. The gate decides whether the array is touched and filters the data that is returned. It keeps a copy of the option byte, which is stored in the top byte of flash. Bit 5 of that byte is the security flag, and bit 0 selects where the part boots.

After reset the state machine reads the option byte from the array (states BOOT_RD, then BOOT_CAP) and then waits in IDLE. When `cmd_valid` is high in IDLE, the command is accepted and its verdict is registered. The machine then goes to EXEC, where the array strobe is issued if the command is granted. A granted read goes from EXEC to RDWAIT and then to RESP. Every other command goes from EXEC straight to RESP. RESP raises `rsp_done` for one cycle and returns to IDLE.

Opcodes: 00 read, 01 byte write, 10 page erase, 11 mass erase. Pages are 128 bytes, so the last page spans 0x7F80 to 0x7FFF. The option byte lives at 0x7FFF, and the read alias for it is 0xFFFF.

Top module: `flash_sec_gate`

## Requirements
- R1: When the part is unsecured, an external read in 0x0000–0x7FFF returns the array byte, and external writes and page erases are granted (`rsp_reject`=0).
- R2: The part is secured when the option byte is programmed and its bit 5 is 1. An external read of 0x0000–0x7FFF on a secured part, including 0x7FFF itself, returns 0xFF with `rsp_reject`=0.
- R3: A read of 0xFFFF returns the current option byte whatever the security state.
- R4: On a secured part, external byte writes to program flash or to 0x7FFF are rejected and issue no array write.
- R5: On a secured part, external page erases are rejected.
- R6: Commands with `cmd_internal`=1 skip the security checks of R2, R4 and R5.
- R7: Once programmed, the option byte rejects any further write, internal or external, until a page erase of the last page or a mass erase.
- R8: An address from 0x8000 to 0xFFFE is rejected for every opcode except mass erase, and 0xFFFF is rejected for writes and page erases. A rejected read returns 0xFF.
- R9: A mass erase is always granted. Afterwards the option byte reads 0xFF, `secured`=0 and `boot_from_flash`=0.
- R10: `boot_from_flash` equals bit 0 of a programmed option byte and is 0 when the byte is erased. `secured` reflects R2.
- R11: Each accepted command produces exactly one `rsp_done` pulse of one cycle. `cmd_ready` is low from acceptance until after that pulse, and at most one array strobe is high in any cycle.
- R12: After reset the gate reads 0x7FFF before raising `cmd_ready`. A loaded value of 0xFF counts as unprogrammed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Gate idle, command accepted when valid |
| cmd_op | input | 2 | Opcode (00 read, 01 write, 10 page erase, 11 mass erase) |
| cmd_addr | input | 16 | Command address |
| cmd_wdata | input | 8 | Write data |
| cmd_internal | input | 1 | Request from internal user routine |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_reject | output | 1 | Command was blocked (valid with rsp_done) |
| rsp_rdata | output | 8 | Filtered read data (valid with rsp_done) |
| arr_rd | output | 1 | Array read strobe, data due next cycle |
| arr_wr | output | 1 | Array byte write strobe |
| arr_page_erase | output | 1 | Array page erase strobe |
| arr_mass_erase | output | 1 | Array mass erase strobe |
| arr_addr | output | 15 | Array address |
| arr_wdata | output | 8 | Array write data |
| arr_rdata | input | 8 | Array read data |
| secured | output | 1 | Security active |
| boot_from_flash | output | 1 | Boot-select from option bit 0 |

## Verification
The bench targets five classes of design fault.
- Reads of 0x7FFF on a secured part must return 0xFF, while the 0xFFFF alias must return the real byte. A gate that mixes up the two addresses either leaks the option contents or hides the byte from the programmer.
- Internal writes to the option byte must still be refused after it has been programmed. A gate that lets the internal flag override the write-once rule would let the byte be rewritten.
- An erase of the last page must re-arm that rule.
- A mass erase must unsecure the part and also switch `boot_from_flash` to 0. A gate that only clears the security bit would keep booting from erased flash.
- After a second reset, the state must come back from the array. A gate that keeps a stale shadow copy, or that treats 0xFF as a programmed byte, is caught there.

// File: rtl/flash_gate_pkg.sv
package flash_gate_pkg;

    typedef enum logic [1:0] {
        OP_READ       = 2'b00,
        OP_WRITE      = 2'b01,
        OP_PAGE_ERASE = 2'b10,
        OP_MASS_ERASE = 2'b11
    } fop_e;

    typedef enum logic [2:0] {
        ST_BOOT_RD,
        ST_BOOT_CAP,
        ST_IDLE,
        ST_EXEC,
        ST_RDWAIT,
        ST_RESP
    } gate_state_e;

    typedef struct packed {
        logic reject;
        logic arr_go;
        logic from_opt;
        logic force_ones;
    } verdict_t;

endpackage

// File: rtl/sec_policy.sv
module sec_policy
    import flash_gate_pkg::*;
#(
    parameter int ADDR_W = 15
) (
    input  fop_e             op,
    input  logic [ADDR_W:0]  addr,
    input  logic             internal,
    input  logic             secured,
    input  logic             opt_prog,
    output verdict_t         verdict
);
    localparam logic [ADDR_W:0] OPT_ADDR   = {1'b0, {ADDR_W{1'b1}}};
    localparam logic [ADDR_W:0] ALIAS_ADDR = {(ADDR_W+1){1'b1}};

    logic in_range, is_alias, is_opt, guarded;

    always_comb begin
        in_range = ~addr[ADDR_W];
        is_alias = (addr == ALIAS_ADDR);
        is_opt   = (addr == OPT_ADDR);
        guarded  = secured && !internal;
    end

    always_comb begin
        verdict = '0;
        unique case (op)
            OP_READ: begin
                if (is_alias)       verdict.from_opt   = 1'b1;
                else if (!in_range) verdict.reject     = 1'b1;
                else if (guarded)   verdict.force_ones = 1'b1;
                else                verdict.arr_go     = 1'b1;
            end
            OP_WRITE: begin
                if (!in_range || guarded)  verdict.reject = 1'b1;
                else if (is_opt && opt_prog) verdict.reject = 1'b1;
                else                       verdict.arr_go = 1'b1;
            end
            OP_PAGE_ERASE: begin
                if (!in_range || guarded) verdict.reject = 1'b1;
                else                      verdict.arr_go = 1'b1;
            end
            OP_MASS_ERASE: verdict.arr_go = 1'b1;
            default:       verdict.reject = 1'b1;
        endcase
    end
endmodule

// File: rtl/opt_shadow.sv
module opt_shadow #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [DATA_W-1:0] load_val,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_val,
    input  logic              clr_en,
    output logic [DATA_W-1:0] opt_q,
    output logic              prog_q
);
    localparam logic [DATA_W-1:0] ERASED = {DATA_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            opt_q  <= ERASED;
            prog_q <= 1'b0;
        end else if (load_en) begin
            opt_q  <= load_val;
            prog_q <= (load_val != ERASED);
        end else if (clr_en) begin
            opt_q  <= ERASED;
            prog_q <= 1'b0;
        end else if (wr_en) begin
            opt_q  <= wr_val;
            prog_q <= 1'b1;
        end
    end
endmodule

// File: rtl/flash_sec_gate.sv
module flash_sec_gate
    import flash_gate_pkg::*;
#(
    parameter int ADDR_W   = 15,
    parameter int PAGE_W   = 7,
    parameter int DATA_W   = 8,
    parameter int SEC_BIT  = 5,
    parameter int BOOT_BIT = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W:0]   cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic              cmd_internal,
    output logic              rsp_done,
    output logic              rsp_reject,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              arr_rd,
    output logic              arr_wr,
    output logic              arr_page_erase,
    output logic              arr_mass_erase,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_wdata,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic              secured,
    output logic              boot_from_flash
);
    localparam logic [ADDR_W:0]   OPT_ADDR  = {1'b0, {ADDR_W{1'b1}}};
    localparam logic [ADDR_W-1:0] OPT_ARR   = {ADDR_W{1'b1}};
    localparam int                PG_IDX_W  = ADDR_W - PAGE_W;
    localparam logic [PG_IDX_W-1:0] LAST_PG = {PG_IDX_W{1'b1}};
    localparam logic [DATA_W-1:0] ALL_ONES  = {DATA_W{1'b1}};

    gate_state_e       state_q, state_d;
    fop_e              ctx_op;
    logic [ADDR_W:0]   ctx_addr;
    logic [DATA_W-1:0] ctx_wdata;
    logic              ctx_int;
    verdict_t          ctx_v, verdict;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] opt_q;
    logic              opt_prog;
    logic              accept;
    logic              exec_go;
    logic              opt_wr, opt_clr;

    assign accept  = (state_q == ST_IDLE) && cmd_valid;
    assign exec_go = (state_q == ST_EXEC) && ctx_v.arr_go;
    assign opt_wr  = exec_go && (ctx_op == OP_WRITE) && (ctx_addr == OPT_ADDR);
    assign opt_clr = exec_go && ((ctx_op == OP_MASS_ERASE) ||
                     ((ctx_op == OP_PAGE_ERASE) && (ctx_addr[ADDR_W-1:PAGE_W] == LAST_PG)));

    assign secured         = opt_prog && opt_q[SEC_BIT];
    assign boot_from_flash = opt_prog && opt_q[BOOT_BIT];

    sec_policy #(.ADDR_W(ADDR_W)) u_policy (
        .op       (fop_e'(cmd_op)),
        .addr     (cmd_addr),
        .internal (cmd_internal),
        .secured  (secured),
        .opt_prog (opt_prog),
        .verdict  (verdict)
    );

    opt_shadow #(.DATA_W(DATA_W)) u_opt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (state_q == ST_BOOT_CAP),
        .load_val (arr_rdata),
        .wr_en    (opt_wr),
        .wr_val   (ctx_wdata),
        .clr_en   (opt_clr),
        .opt_q    (opt_q),
        .prog_q   (opt_prog)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_BOOT_RD;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_BOOT_RD:  state_d = ST_BOOT_CAP;
            ST_BOOT_CAP: state_d = ST_IDLE;
            ST_IDLE:     if (accept) state_d = ST_EXEC;
            ST_EXEC:     state_d = (ctx_op == OP_READ && ctx_v.arr_go) ? ST_RDWAIT : ST_RESP;
            ST_RDWAIT:   state_d = ST_RESP;
            ST_RESP:     state_d = ST_IDLE;
            default:     state_d = ST_BOOT_RD;
        endcase
    end

    // command context and response data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctx_op    <= OP_READ;
            ctx_addr  <= '0;
            ctx_wdata <= '0;
            ctx_int   <= 1'b0;
            ctx_v     <= '0;
            rdata_q   <= ALL_ONES;
        end else begin
            if (accept) begin
                ctx_op    <= fop_e'(cmd_op);
                ctx_addr  <= cmd_addr;
                ctx_wdata <= cmd_wdata;
                ctx_int   <= cmd_internal;
                ctx_v     <= verdict;
            end
            if (state_q == ST_EXEC) begin
                if (ctx_v.from_opt)                         rdata_q <= opt_q;
                else if (ctx_v.force_ones || ctx_v.reject)  rdata_q <= ALL_ONES;
            end else if (state_q == ST_RDWAIT) begin
                rdata_q <= arr_rdata;
            end
        end
    end

    // outputs
    always_comb begin
        cmd_ready      = 1'b0;
        rsp_done       = 1'b0;
        arr_rd         = 1'b0;
        arr_wr         = 1'b0;
        arr_page_erase = 1'b0;
        arr_mass_erase = 1'b0;
        arr_addr       = ctx_addr[ADDR_W-1:0];
        arr_wdata      = ctx_wdata;
        unique case (state_q)
            ST_BOOT_RD: begin
                arr_rd   = 1'b1;
                arr_addr = OPT_ARR;
            end
            ST_IDLE: cmd_ready = 1'b1;
            ST_EXEC: begin
                if (ctx_v.arr_go) begin
                    unique case (ctx_op)
                        OP_READ:       arr_rd         = 1'b1;
                        OP_WRITE:      arr_wr         = 1'b1;
                        OP_PAGE_ERASE: arr_page_erase = 1'b1;
                        OP_MASS_ERASE: arr_mass_erase = 1'b1;
                        default:       arr_rd         = 1'b0;
                    endcase
                end
            end
            ST_RESP: rsp_done = 1'b1;
            default: cmd_ready = 1'b0;
        endcase
    end

    assign rsp_reject = rsp_done && ctx_v.reject;
    assign rsp_rdata  = rdata_q;

endmodule

// File: rtl/sec_gate_chk.sv
module sec_gate_chk #(
    parameter int ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_ready,
    input logic              rsp_done,
    input logic              arr_rd,
    input logic              arr_wr,
    input logic              arr_page_erase,
    input logic              arr_mass_erase,
    input logic [ADDR_W-1:0] arr_addr,
    input logic              secured,
    input logic              boot_from_flash,
    input logic              ctx_int,
    input logic              opt_prog
);
    p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    p_done_not_ready_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> !cmd_ready);

    p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({arr_rd, arr_wr, arr_page_erase, arr_mass_erase}));

    p_sec_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr && secured) |-> ctx_int);

    p_sec_erase_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_page_erase && secured) |-> ctx_int);

    p_opt_once_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_wr && (arr_addr == {ADDR_W{1'b1}})) |-> !opt_prog);

    p_mass_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        arr_mass_erase |=> (!secured && !boot_from_flash));
endmodule

bind flash_sec_gate sec_gate_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cmd_ready       (cmd_ready),
    .rsp_done        (rsp_done),
    .arr_rd          (arr_rd),
    .arr_wr          (arr_wr),
    .arr_page_erase  (arr_page_erase),
    .arr_mass_erase  (arr_mass_erase),
    .arr_addr        (arr_addr),
    .secured         (secured),
    .boot_from_flash (boot_from_flash),
    .ctx_int         (ctx_int),
    .opt_prog        (opt_prog)
);

// File: tb/sim_flash_sec_gate.sv
module sim_flash_sec_gate;
    localparam logic [1:0] RD = 2'b00, WR = 2'b01, PE = 2'b10, ME = 2'b11;
    localparam int NV = 24;
    // {req[3:0], op[1:0], internal, addr[15:0], wdata[7:0], exp_reject, exp_rdata[7:0], check_rdata}
    localparam logic [40:0] VECS [NV] = '{
        {4'd2,  RD, 1'b0, 16'h0100, 8'h00, 1'b0, 8'hFF, 1'b1}, // R2 secured read
        {4'd6,  RD, 1'b1, 16'h0100, 8'h00, 1'b0, 8'h5A, 1'b1}, // R6 internal read
        {4'd3,  RD, 1'b0, 16'hFFFF, 8'h00, 1'b0, 8'h21, 1'b1}, // R3 alias
        {4'd2,  RD, 1'b0, 16'h7FFF, 8'h00, 1'b0, 8'hFF, 1'b1}, // R2 physical option addr
        {4'd4,  WR, 1'b0, 16'h0100, 8'h55, 1'b1, 8'h00, 1'b0}, // R4
        {4'd5,  PE, 1'b0, 16'h0000, 8'h00, 1'b1, 8'h00, 1'b0}, // R5
        {4'd8,  RD, 1'b0, 16'h8000, 8'h00, 1'b1, 8'hFF, 1'b1}, // R8
        {4'd6,  WR, 1'b1, 16'h0200, 8'h33, 1'b0, 8'h00, 1'b0}, // R6 internal write
        {4'd6,  RD, 1'b1, 16'h0200, 8'h00, 1'b0, 8'h33, 1'b1}, // R6
        {4'd4,  WR, 1'b0, 16'h7FFF, 8'h00, 1'b1, 8'h00, 1'b0}, // R4 option write
        {4'd7,  WR, 1'b1, 16'h7FFF, 8'h00, 1'b1, 8'h00, 1'b0}, // R7 internal rewrite
        {4'd9,  ME, 1'b0, 16'h1234, 8'h00, 1'b0, 8'h00, 1'b0}, // R9
        {4'd1,  RD, 1'b0, 16'h0100, 8'h00, 1'b0, 8'hFF, 1'b1}, // R1 erased
        {4'd9,  RD, 1'b0, 16'hFFFF, 8'h00, 1'b0, 8'hFF, 1'b1}, // R9 option erased
        {4'd1,  WR, 1'b0, 16'h0100, 8'hA5, 1'b0, 8'h00, 1'b0}, // R1
        {4'd1,  RD, 1'b0, 16'h0100, 8'h00, 1'b0, 8'hA5, 1'b1}, // R1
        {4'd7,  WR, 1'b0, 16'h7FFF, 8'h01, 1'b0, 8'h00, 1'b0}, // R7 first write
        {4'd7,  WR, 1'b0, 16'h7FFF, 8'h20, 1'b1, 8'h00, 1'b0}, // R7 second write
        {4'd3,  RD, 1'b0, 16'hFFFF, 8'h00, 1'b0, 8'h01, 1'b1}, // R3
        {4'd7,  PE, 1'b0, 16'h7F80, 8'h00, 1'b0, 8'h00, 1'b0}, // R7 last page erase
        {4'd7,  RD, 1'b0, 16'hFFFF, 8'h00, 1'b0, 8'hFF, 1'b1}, // R7
        {4'd7,  WR, 1'b0, 16'h7FFF, 8'h20, 1'b0, 8'h00, 1'b0}, // R7 rewrite allowed
        {4'd5,  PE, 1'b0, 16'h0100, 8'h00, 1'b1, 8'h00, 1'b0}, // R5 secured again
        {4'd8,  WR, 1'b0, 16'hFFFF, 8'h00, 1'b1, 8'h00, 1'b0}  // R8 alias write
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = 2'b00;
    logic [15:0] cmd_addr = '0;
    logic [7:0]  cmd_wdata = '0;
    logic        cmd_internal = 1'b0;
    logic        rsp_done, rsp_reject;
    logic [7:0]  rsp_rdata;
    logic        arr_rd, arr_wr, arr_page_erase, arr_mass_erase;
    logic [14:0] arr_addr;
    logic [7:0]  arr_wdata;
    logic [7:0]  arr_rdata = 8'hFF;
    logic        secured, boot_from_flash;

    int checks = 0;
    int errors = 0;
    logic [7:0] mem [int];

    always #10 clk = ~clk;

    flash_sec_gate u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .cmd_internal(cmd_internal), .rsp_done(rsp_done), .rsp_reject(rsp_reject),
        .rsp_rdata(rsp_rdata), .arr_rd(arr_rd), .arr_wr(arr_wr),
        .arr_page_erase(arr_page_erase), .arr_mass_erase(arr_mass_erase),
        .arr_addr(arr_addr), .arr_wdata(arr_wdata), .arr_rdata(arr_rdata),
        .secured(secured), .boot_from_flash(boot_from_flash)
    );

    // simple flash model: absent entries read as erased
    always @(posedge clk) begin
        if (arr_rd) arr_rdata <= mem.exists(int'(arr_addr)) ? mem[int'(arr_addr)] : 8'hFF;
        if (arr_wr) mem[int'(arr_addr)] = arr_wdata;
        if (arr_page_erase) begin
            for (int i = 0; i < 128; i++) begin
                int a;
                a = (int'(arr_addr) & ~127) + i;
                if (mem.exists(a)) mem.delete(a);
            end
        end
        if (arr_mass_erase) mem.delete();
    end

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic run_cmd(input logic [1:0] op, input logic intl, input logic [15:0] addr,
                           input logic [7:0] wd, output logic rej, output logic [7:0] rd,
                           output logic pulse_ok);
        int n;
        n = 0;
        while (!cmd_ready && n < 20) begin @(negedge clk); n++; end
        cmd_op = op; cmd_internal = intl; cmd_addr = addr; cmd_wdata = wd;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        n = 0;
        while (!rsp_done && n < 20) begin @(negedge clk); n++; end
        rej = rsp_reject;
        rd  = rsp_rdata;
        @(negedge clk);
        pulse_ok = !rsp_done && cmd_ready;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic rej, pok;
        logic [7:0] rd;
        mem[32'h7FFF] = 8'h21;
        mem[32'h0100] = 8'h5A;
        repeat (3) @(negedge clk);
        check("R11 reset done", {7'b0, rsp_done}, 8'h00);
        check("R12 ready held in reset", {7'b0, cmd_ready}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 not ready during boot read", {7'b0, cmd_ready}, 8'h00);
        @(negedge clk);
        @(negedge clk);
        check("R12 ready after load", {7'b0, cmd_ready}, 8'h01);
        check("R10 secured from 0x21", {7'b0, secured}, 8'h01);
        check("R10 boot from 0x21", {7'b0, boot_from_flash}, 8'h01);

        for (int k = 0; k < NV; k++) begin
            logic [40:0] v;
            string tag;
            v = VECS[k];
            run_cmd(v[36:35], v[34], v[33:18], v[17:10], rej, rd, pok);
            tag = $sformatf("R%0d vec%0d reject", v[40:37], k);
            check(tag, {7'b0, rej}, {7'b0, v[9]});
            if (v[0]) check($sformatf("R%0d vec%0d data", v[40:37], k), rd, v[8:1]);
            check($sformatf("R11 vec%0d single pulse", k), {7'b0, pok}, 8'h01);
            if (k == 11) begin
                check("R9 unsecured after mass erase", {7'b0, secured}, 8'h00);
                check("R10 boot rom after mass erase", {7'b0, boot_from_flash}, 8'h00);
            end
            if (k == 16) begin
                check("R10 boot from 0x01", {7'b0, boot_from_flash}, 8'h01);
                check("R10 unsecured 0x01", {7'b0, secured}, 8'h00);
            end
        end
        check("R10 secured from 0x20", {7'b0, secured}, 8'h01);
        check("R10 boot rom from 0x20", {7'b0, boot_from_flash}, 8'h00);

        // R6 internal page erase on a secured part
        run_cmd(PE, 1'b1, 16'h0200, 8'h00, rej, rd, pok);
        check("R6 internal page erase granted", {7'b0, rej}, 8'h00);
        run_cmd(RD, 1'b1, 16'h0200, 8'h00, rej, rd, pok);
        check("R6 page erased data", rd, 8'hFF);
        // R8 page erase at alias
        run_cmd(PE, 1'b1, 16'hFFFF, 8'h00, rej, rd, pok);
        check("R8 alias page erase rejected", {7'b0, rej}, 8'h01);

        // R12 reload after second reset
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 reset clears secured", {7'b0, secured}, 8'h00);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R12 reload secured", {7'b0, secured}, 8'h01);
        run_cmd(RD, 1'b0, 16'hFFFF, 8'h00, rej, rd, pok);
        check("R12 reloaded option via alias", rd, 8'h20);
        run_cmd(RD, 1'b0, 16'h0100, 8'h00, rej, rd, pok);
        check("R2 secured read after reload", rd, 8'hFF);

        // R12 erased option byte counts as unprogrammed
        run_cmd(ME, 1'b0, 16'h0000, 8'h00, rej, rd, pok);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R12 erased load unsecured", {7'b0, secured}, 8'h00);
        run_cmd(WR, 1'b0, 16'h7FFF, 8'h21, rej, rd, pok);
        check("R12 erased load allows option write", {7'b0, rej}, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule